// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block sits beside the decode stage of a hart that implements the hypervisor extension. Decode hands it one system instruction at a time as a class code, together with the current privilege level, the virtualization flag and a handful of trap-control bits. In the same cycle the block settles on one of four verdicts: raise an illegal-instruction exception, raise a virtual-instruction exception, let the instruction proceed, or, for wait-for-interrupt, halt the hart. It never touches memory or translation; it only judges whether the instruction may run.

The checks are layered. One control bit can produce different causes depending on whether the hart is virtualized and which privilege it runs at, and the order of the checks matters where more than one of them applies. The design is purely combinational, so it has no states or transitions. It is split into one small checker per instruction family, and a selector picks the verdict of the family named by the class code.

Top module: `priv_trap_check`

## Requirements
- R1: Privilege is encoded 0 = user, 1 = supervisor, 3 = machine. The exception cause is 2 for illegal instruction and 22 for virtual instruction. Class codes: 0 block zero, 1 block clean/flush, 2 block invalidate, 3 wait-for-interrupt, 4 wait-on-reservation without timeout, 5 supervisor fence, 6 hypervisor virtual-machine fence, 7 hypervisor guest-physical fence, 8 hypervisor virtual load/store. Bit k of each environment-enable input enables the block operation with class code k.
- R2: While `inst_valid` is high, exactly one of `exc_valid`, `proceed` and `halt` is high. While it is low, all three are low and `exc_cause` is 0.
- R3: A block operation below machine level whose machine enable bit is clear raises illegal instruction. This check overrides every other check on block operations. At machine level a block operation always proceeds.
- R4: Failing R3 does not apply, a virtualized block operation raises virtual instruction if the privilege is supervisor or user and the hypervisor enable bit is clear, or if the privilege is user and the supervisor enable bit is clear.
- R5: Failing R3 and R4 do not apply, a block operation in user mode with the supervisor enable bit clear raises illegal instruction. Otherwise it proceeds.
- R6: Wait-for-interrupt raises illegal instruction when TW is set in supervisor mode, when TW is set in user mode on a hart without supervisor mode, or when in non-virtualized user mode on a hart with supervisor mode.
- R7: Failing R6 does not apply, wait-for-interrupt raises virtual instruction when virtualized and either in user mode or in supervisor mode with VTW set. Otherwise it asserts `halt`.
- R8: Wait-on-reservation raises virtual instruction when virtualized in supervisor or user mode with VTW set and TW clear. Failing that, it raises illegal instruction below machine level with TW set. Otherwise it proceeds and never halts.
- R9: The supervisor fence raises illegal instruction when not virtualized in user mode, or in supervisor mode with TVM set. When virtualized, it raises virtual instruction in user mode or with VTVM set, and TVM has no effect. Otherwise it proceeds.
- R10: The hypervisor fences raise virtual instruction whenever virtualized. They proceed at machine level or in non-virtualized supervisor mode, and otherwise raise illegal instruction. The guest-physical fence also raises illegal instruction in non-virtualized supervisor mode with TVM set.
- R11: Hypervisor virtual loads and stores proceed at machine level. Below machine level they raise virtual instruction when virtualized, and raise illegal instruction in user mode with HU clear. Otherwise they proceed.
- R12: Class codes 9 to 15 raise illegal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_valid | input | 1 | A system instruction is presented |
| inst_class | input | 4 | Instruction class code (R1) |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Hart runs virtualized |
| mst_tw | input | 1 | Machine status: trap wait |
| mst_tvm | input | 1 | Machine status: trap virtual memory |
| hst_vtw | input | 1 | Hypervisor status: trap guest wait |
| hst_vtvm | input | 1 | Hypervisor status: trap guest virtual memory |
| hst_hu | input | 1 | Hypervisor status: user access to hypervisor loads/stores |
| menv_cb | input | 3 | Machine-level block-operation enables |
| henv_cb | input | 3 | Hypervisor-level block-operation enables |
| senv_cb | input | 3 | Supervisor-level block-operation enables |
| exc_valid | output | 1 | Raise an exception |
| exc_cause | output | 5 | Exception cause code |
| proceed | output | 1 | Instruction may execute |
| halt | output | 1 | Wait-for-interrupt halts the hart |

## Verification
Each instruction family is driven through every privilege level, with the virtualization flag both set and clear. For each family the one control bit that matters is toggled while the others are held at their permissive values, so that each check can be told apart from the rest. Where two checks could fire together, the vectors set both to show which one wins: the machine enable against the hypervisor enable, TW against VTW, and TVM against virtualization. A second instance built for a hart without supervisor mode separates the two wait-for-interrupt rules for user mode. The bench also checks that the selector gives an idle output when nothing is presented and an illegal-instruction verdict for undefined class codes.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;
    localparam int PRIV_W  = 2;
    localparam int CLASS_W = 4;
    localparam int CAUSE_W = 5;
    localparam int CBO_OPS = 3;

    localparam logic [PRIV_W-1:0]  PRIV_U = 2'd0;
    localparam logic [PRIV_W-1:0]  PRIV_S = 2'd1;
    localparam logic [PRIV_W-1:0]  PRIV_M = 2'd3;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = 5'd22;

    typedef enum logic [CLASS_W-1:0] {
        CLS_CB_ZERO      = 4'd0,
        CLS_CB_CLEAN     = 4'd1,
        CLS_CB_INVAL     = 4'd2,
        CLS_WFI          = 4'd3,
        CLS_WRS_NTO      = 4'd4,
        CLS_SFENCE       = 4'd5,
        CLS_HFENCE_VM    = 4'd6,
        CLS_HFENCE_GUEST = 4'd7,
        CLS_HYP_LDST     = 4'd8
    } cls_e;

    typedef enum logic [1:0] {
        VERD_GO   = 2'd0,
        VERD_HALT = 2'd1,
        VERD_ILL  = 2'd2,
        VERD_VIRT = 2'd3
    } verdict_e;
endpackage

// File: rtl/ptrap_cbo.sv
module ptrap_cbo
    import ptrap_pkg::*;
(
    input  logic [CBO_OPS-1:0] cb_hit,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               virt_on,
    input  logic [CBO_OPS-1:0] menv_cb,
    input  logic [CBO_OPS-1:0] henv_cb,
    input  logic [CBO_OPS-1:0] senv_cb,
    output verdict_e           verdict
);
    logic m_en, h_en, s_en;
    logic below_m, s_or_u, is_u;

    always_comb begin
        m_en    = |(menv_cb & cb_hit);
        h_en    = |(henv_cb & cb_hit);
        s_en    = |(senv_cb & cb_hit);
        below_m = (cur_priv != PRIV_M);
        is_u    = (cur_priv == PRIV_U);
        s_or_u  = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);

        if (below_m && !m_en)
            verdict = VERD_ILL;
        else if (virt_on && ((s_or_u && !h_en) || (is_u && !s_en)))
            verdict = VERD_VIRT;
        else if (is_u && !s_en)
            verdict = VERD_ILL;
        else
            verdict = VERD_GO;
    end

    always_comb begin
        if ((|cb_hit) && cur_priv == PRIV_M)
            AST_CBO_MACHINE_FREE: assert (verdict == VERD_GO); // R3
        if ((|cb_hit) && !virt_on)
            AST_CBO_PLAIN_NO_VIRT: assert (verdict != VERD_VIRT); // R4
    end
endmodule

// File: rtl/ptrap_wait.sv
module ptrap_wait
    import ptrap_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic              is_wfi,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              virt_on,
    input  logic              mst_tw,
    input  logic              hst_vtw,
    output verdict_e          verdict
);
    logic is_u, is_s, wfi_ill, wfi_virt, wrs_virt, wrs_ill;

    always_comb begin
        is_u     = (cur_priv == PRIV_U);
        is_s     = (cur_priv == PRIV_S);
        wfi_ill  = ((is_s || (!HAS_SMODE && is_u)) && mst_tw) ||
                   (HAS_SMODE && is_u && !virt_on);
        wfi_virt = virt_on && (is_u || (is_s && hst_vtw));
        wrs_virt = virt_on && (is_s || is_u) && hst_vtw && !mst_tw;
        wrs_ill  = (cur_priv != PRIV_M) && mst_tw;

        if (is_wfi)
            verdict = wfi_ill ? VERD_ILL : (wfi_virt ? VERD_VIRT : VERD_HALT);
        else
            verdict = wrs_virt ? VERD_VIRT : (wrs_ill ? VERD_ILL : VERD_GO);
    end

    always_comb begin
        if (is_wfi && cur_priv == PRIV_M)
            AST_WFI_MACHINE_HALTS: assert (verdict == VERD_HALT); // R7
        if (!is_wfi)
            AST_WRS_NEVER_HALTS: assert (verdict != VERD_HALT); // R8
    end
endmodule

// File: rtl/ptrap_fence.sv
module ptrap_fence
    import ptrap_pkg::*;
(
    input  logic              is_hyp,
    input  logic              is_guest,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              virt_on,
    input  logic              mst_tvm,
    input  logic              hst_vtvm,
    output verdict_e          verdict
);
    logic is_u, is_s, is_m;

    always_comb begin
        is_u = (cur_priv == PRIV_U);
        is_s = (cur_priv == PRIV_S);
        is_m = (cur_priv == PRIV_M);
        if (!is_hyp) begin
            if (!virt_on && (is_u || (is_s && mst_tvm)))
                verdict = VERD_ILL;
            else if (virt_on && (is_u || hst_vtvm))
                verdict = VERD_VIRT;
            else
                verdict = VERD_GO;
        end else begin
            if (is_guest && is_s && !virt_on && mst_tvm)
                verdict = VERD_ILL;
            else if (virt_on)
                verdict = VERD_VIRT;
            else if (is_m || is_s)
                verdict = VERD_GO;
            else
                verdict = VERD_ILL;
        end
    end

    always_comb begin
        if (is_hyp && virt_on)
            AST_HFENCE_GUEST_TRAPS: assert (verdict == VERD_VIRT); // R10
        if (!is_hyp && virt_on && !is_u && !hst_vtvm)
            AST_SFENCE_TVM_IGNORED: assert (verdict == VERD_GO); // R9
    end
endmodule

// File: rtl/ptrap_hlsv.sv
module ptrap_hlsv
    import ptrap_pkg::*;
(
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              virt_on,
    input  logic              hst_hu,
    output verdict_e          verdict
);
    always_comb begin
        if (cur_priv == PRIV_M)
            verdict = VERD_GO;
        else if (virt_on)
            verdict = VERD_VIRT;
        else if (cur_priv == PRIV_U && !hst_hu)
            verdict = VERD_ILL;
        else
            verdict = VERD_GO;
    end

    always_comb begin
        if (cur_priv == PRIV_M)
            AST_HLSV_MACHINE_OK: assert (verdict == VERD_GO); // R11
    end
endmodule

// File: rtl/priv_trap_check.sv
module priv_trap_check
    import ptrap_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic               inst_valid,
    input  logic [CLASS_W-1:0] inst_class,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               virt_on,
    input  logic               mst_tw,
    input  logic               mst_tvm,
    input  logic               hst_vtw,
    input  logic               hst_vtvm,
    input  logic               hst_hu,
    input  logic [CBO_OPS-1:0] menv_cb,
    input  logic [CBO_OPS-1:0] henv_cb,
    input  logic [CBO_OPS-1:0] senv_cb,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               proceed,
    output logic               halt
);
    logic [CBO_OPS-1:0] cb_hit;
    verdict_e v_cbo, v_wait, v_fence, v_hlsv, v_sel;

    for (genvar gi = 0; gi < CBO_OPS; gi++) begin : g_cb_hit
        assign cb_hit[gi] = (inst_class == CLASS_W'(gi));
    end

    ptrap_cbo u_cbo (
        .cb_hit   (cb_hit),
        .cur_priv (cur_priv),
        .virt_on  (virt_on),
        .menv_cb  (menv_cb),
        .henv_cb  (henv_cb),
        .senv_cb  (senv_cb),
        .verdict  (v_cbo)
    );

    ptrap_wait #(.HAS_SMODE(HAS_SMODE)) u_wait (
        .is_wfi   (inst_class == CLS_WFI),
        .cur_priv (cur_priv),
        .virt_on  (virt_on),
        .mst_tw   (mst_tw),
        .hst_vtw  (hst_vtw),
        .verdict  (v_wait)
    );

    ptrap_fence u_fence (
        .is_hyp   ((inst_class == CLS_HFENCE_VM) || (inst_class == CLS_HFENCE_GUEST)),
        .is_guest (inst_class == CLS_HFENCE_GUEST),
        .cur_priv (cur_priv),
        .virt_on  (virt_on),
        .mst_tvm  (mst_tvm),
        .hst_vtvm (hst_vtvm),
        .verdict  (v_fence)
    );

    ptrap_hlsv u_hlsv (
        .cur_priv (cur_priv),
        .virt_on  (virt_on),
        .hst_hu   (hst_hu),
        .verdict  (v_hlsv)
    );

    always_comb begin
        unique case (inst_class)
            CLS_CB_ZERO, CLS_CB_CLEAN, CLS_CB_INVAL:      v_sel = v_cbo;
            CLS_WFI, CLS_WRS_NTO:                         v_sel = v_wait;
            CLS_SFENCE, CLS_HFENCE_VM, CLS_HFENCE_GUEST:  v_sel = v_fence;
            CLS_HYP_LDST:                                 v_sel = v_hlsv;
            default:                                      v_sel = VERD_ILL;
        endcase
    end

    always_comb begin
        exc_valid = inst_valid && (v_sel == VERD_ILL || v_sel == VERD_VIRT);
        proceed   = inst_valid && (v_sel == VERD_GO);
        halt      = inst_valid && (v_sel == VERD_HALT);
        exc_cause = '0;
        if (inst_valid && v_sel == VERD_ILL)  exc_cause = CAUSE_ILLEGAL;
        if (inst_valid && v_sel == VERD_VIRT) exc_cause = CAUSE_VIRTUAL;
    end

    always_comb begin
        if (inst_valid)
            AST_ONE_OUTCOME: assert ($countones({exc_valid, proceed, halt}) == 1); // R2
        else
            AST_IDLE_QUIET: assert (!exc_valid && !proceed && !halt && exc_cause == '0); // R2
        if (exc_valid)
            AST_CAUSE_LEGAL: assert (exc_cause == CAUSE_ILLEGAL || exc_cause == CAUSE_VIRTUAL); // R1
        if (inst_valid && inst_class > CLS_HYP_LDST)
            AST_UNDEF_ILLEGAL: assert (exc_cause == CAUSE_ILLEGAL); // R12
    end
endmodule

// File: tb/priv_trap_check_tb.sv
`timescale 1ns/1ps
module priv_trap_check_tb;
    localparam int GO = 0, HLT = 1, ILL = 2, VIR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       inst_valid = 1'b0;
    logic [3:0] inst_class = 4'd0;
    logic [1:0] cur_priv = 2'd3;
    logic       virt_on = 1'b0;
    logic       mst_tw = 1'b0, mst_tvm = 1'b0;
    logic       hst_vtw = 1'b0, hst_vtvm = 1'b0, hst_hu = 1'b0;
    logic [2:0] menv_cb = 3'b111, henv_cb = 3'b111, senv_cb = 3'b111;

    logic       exc_a, pro_a, hlt_a, exc_b, pro_b, hlt_b;
    logic [4:0] cau_a, cau_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    priv_trap_check u_dut (
        .inst_valid(inst_valid), .inst_class(inst_class), .cur_priv(cur_priv),
        .virt_on(virt_on), .mst_tw(mst_tw), .mst_tvm(mst_tvm), .hst_vtw(hst_vtw),
        .hst_vtvm(hst_vtvm), .hst_hu(hst_hu), .menv_cb(menv_cb), .henv_cb(henv_cb),
        .senv_cb(senv_cb), .exc_valid(exc_a), .exc_cause(cau_a), .proceed(pro_a),
        .halt(hlt_a)
    );

    priv_trap_check #(.HAS_SMODE(1'b0)) u_dut_nos (
        .inst_valid(inst_valid), .inst_class(inst_class), .cur_priv(cur_priv),
        .virt_on(virt_on), .mst_tw(mst_tw), .mst_tvm(mst_tvm), .hst_vtw(hst_vtw),
        .hst_vtvm(hst_vtvm), .hst_hu(hst_hu), .menv_cb(menv_cb), .henv_cb(henv_cb),
        .senv_cb(senv_cb), .exc_valid(exc_b), .exc_cause(cau_b), .proceed(pro_b),
        .halt(hlt_b)
    );

    task automatic defaults();
        @(negedge clk);
        mst_tw = 0; mst_tvm = 0; hst_vtw = 0; hst_vtvm = 0; hst_hu = 0;
        menv_cb = 3'b111; henv_cb = 3'b111; senv_cb = 3'b111;
    endtask

    task automatic put(input logic [3:0] c, input logic [1:0] p, input logic v);
        @(negedge clk);
        inst_valid = 1'b1; inst_class = c; cur_priv = p; virt_on = v;
    endtask

    task automatic expect_out(input int exp, input string tag, input bit nos = 1'b0);
        logic [7:0] act, want;
        #1;
        act  = nos ? {exc_b, cau_b, pro_b, hlt_b} : {exc_a, cau_a, pro_a, hlt_a};
        case (exp)
            GO:      want = {1'b0, 5'd0,  1'b1, 1'b0};
            HLT:     want = {1'b0, 5'd0,  1'b0, 1'b1};
            ILL:     want = {1'b1, 5'd2,  1'b0, 1'b0};
            default: want = {1'b1, 5'd22, 1'b0, 1'b0};
        endcase
        checks++;
        if (act !== want) begin
            errors++;
            $display("FAIL %s: {exc,cause,proceed,halt} actual=%b expected=%b", tag, act, want);
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        inst_valid = 1'b0; inst_class = 4'd3; cur_priv = 2'd1;
        #1; checks++;
        if ({exc_a, cau_a, pro_a, hlt_a} !== 8'd0) begin
            errors++;
            $display("FAIL R2 idle: actual=%b expected=%b", {exc_a, cau_a, pro_a, hlt_a}, 8'd0);
        end
    endtask

    task automatic t_cbo();
        defaults(); menv_cb = 3'b000; henv_cb = 3'b000;
        put(4'd0, 2'd1, 1'b1); expect_out(ILL, "R3 machine enable wins over hypervisor");
        put(4'd0, 2'd3, 1'b0); expect_out(GO,  "R3 machine level free");
        defaults(); henv_cb = 3'b101;
        put(4'd1, 2'd1, 1'b1); expect_out(VIR, "R4 hypervisor clean enable clear");
        put(4'd0, 2'd1, 1'b1); expect_out(GO,  "R4 other op enabled");
        defaults(); senv_cb = 3'b011;
        put(4'd2, 2'd0, 1'b1); expect_out(VIR, "R4 guest user supervisor enable clear");
        defaults(); senv_cb = 3'b110;
        put(4'd0, 2'd0, 1'b0); expect_out(ILL, "R5 user supervisor enable clear");
        put(4'd0, 2'd1, 1'b0); expect_out(GO,  "R5 supervisor not checked");
    endtask

    task automatic t_wfi();
        defaults(); mst_tw = 1;
        put(4'd3, 2'd1, 1'b0); expect_out(ILL, "R6 TW supervisor");
        put(4'd3, 2'd0, 1'b0); expect_out(ILL, "R6 TW user no smode", 1'b1);
        defaults();
        put(4'd3, 2'd0, 1'b0); expect_out(ILL, "R6 plain user with smode");
        put(4'd3, 2'd0, 1'b0); expect_out(HLT, "R7 user no smode TW clear", 1'b1);
        put(4'd3, 2'd0, 1'b1); expect_out(VIR, "R7 guest user");
        put(4'd3, 2'd1, 1'b1); expect_out(HLT, "R7 guest supervisor VTW clear");
        hst_vtw = 1;
        put(4'd3, 2'd1, 1'b1); expect_out(VIR, "R7 guest supervisor VTW set");
        mst_tw = 1;
        put(4'd3, 2'd3, 1'b0); expect_out(HLT, "R7 machine halts");
    endtask

    task automatic t_wrs();
        defaults(); hst_vtw = 1;
        put(4'd4, 2'd1, 1'b1); expect_out(VIR, "R8 guest VTW TW clear");
        mst_tw = 1;
        put(4'd4, 2'd1, 1'b1); expect_out(ILL, "R8 TW set wins");
        put(4'd4, 2'd3, 1'b0); expect_out(GO,  "R8 machine proceeds");
        defaults();
        put(4'd4, 2'd0, 1'b0); expect_out(GO,  "R8 user TW clear proceeds");
    endtask

    task automatic t_sfence();
        defaults();
        put(4'd5, 2'd0, 1'b0); expect_out(ILL, "R9 plain user");
        put(4'd5, 2'd1, 1'b0); expect_out(GO,  "R9 supervisor TVM clear");
        mst_tvm = 1;
        put(4'd5, 2'd1, 1'b0); expect_out(ILL, "R9 supervisor TVM set");
        put(4'd5, 2'd1, 1'b1); expect_out(GO,  "R9 TVM ignored when virtualized");
        put(4'd5, 2'd0, 1'b1); expect_out(VIR, "R9 guest user");
        hst_vtvm = 1;
        put(4'd5, 2'd1, 1'b1); expect_out(VIR, "R9 VTVM set");
    endtask

    task automatic t_hfence();
        defaults();
        put(4'd6, 2'd1, 1'b1); expect_out(VIR, "R10 vm fence virtualized");
        put(4'd6, 2'd1, 1'b0); expect_out(GO,  "R10 vm fence supervisor");
        put(4'd6, 2'd0, 1'b0); expect_out(ILL, "R10 vm fence user");
        mst_tvm = 1;
        put(4'd6, 2'd1, 1'b0); expect_out(GO,  "R10 vm fence ignores TVM");
        put(4'd7, 2'd1, 1'b0); expect_out(ILL, "R10 guest fence TVM");
        put(4'd7, 2'd1, 1'b1); expect_out(VIR, "R10 guest fence virtualized");
        put(4'd7, 2'd3, 1'b0); expect_out(GO,  "R10 guest fence machine");
    endtask

    task automatic t_hlsv();
        defaults();
        put(4'd8, 2'd3, 1'b0); expect_out(GO,  "R11 machine");
        put(4'd8, 2'd1, 1'b1); expect_out(VIR, "R11 virtualized");
        put(4'd8, 2'd0, 1'b0); expect_out(ILL, "R11 user HU clear");
        put(4'd8, 2'd1, 1'b0); expect_out(GO,  "R11 supervisor");
        hst_hu = 1;
        put(4'd8, 2'd0, 1'b0); expect_out(GO,  "R11 user HU set");
    endtask

    task automatic t_undef();
        defaults();
        put(4'd9,  2'd3, 1'b0); expect_out(ILL, "R12 code 9");
        put(4'd15, 2'd3, 1'b0); expect_out(ILL, "R12 code 15");
        put(4'd8,  2'd3, 1'b0); expect_out(GO,  "R1 code 8 defined");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_cbo();
        t_wfi();
        t_wrs();
        t_sfence();
        t_hfence();
        t_hlsv();
        t_undef();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule